// File: doc/BRIEF.md
# CPU/PCI Frequency Selector with Fine-Step Slewing

This block produces the operating CPU and PCI frequency words for a system clock synthesizer. A 5-bit index picks one of 32 preset CPU/PCI frequency pairs. The low four index bits come either from latched board straps or from control-register bits, and the top bit always comes from a register bit. A signed fine offset then moves the CPU target away from the preset in steps of 0.22 MHz. The PCI frequency is scaled by the same ratio as the CPU frequency.

The CPU word never jumps once it is running. On each pulse of a step strobe it moves toward the target by at most one fine step, so a new setting is reached as a gradual ramp. The block also reports the spread-spectrum style for the selected preset: off, center or down-spread. Producing the actual clocks belongs to downstream logic. All frequencies are integers in units of 10 kHz.

Top module: `freq_microstep`

## Requirements
- R1: While reset is asserted, cpu_freq, pci_freq and spread_mode are 0. At the first clock edge after release, cpu_freq takes the full target value directly, without ramping.
- R2: The preset index is {idx_hi, low nibble}. When use_reg_sel is 1, the low nibble is reg_fs. When use_reg_sel is 0, the low nibble is strap_fs. The unselected nibble has no effect on the outputs.
- R3: The preset table in 10 kHz units includes these CPU/PCI pairs: index 0 = 12400/4130, 3 = 6680/3340, 6 = 13330/4440, 7 = 10000/3330, 22 = 13650/3410. Index 23, 24 and 31 hold CPU 10000, 12000 and 13330.
- R4: fine_offset[7] is the sign (1 = subtract) and fine_offset[6:0] is the magnitude M. The target is preset_cpu ± STEP·M, where STEP = 22. A negative zero gives the preset itself.
- R5: On a clock with step_tick high, cpu_freq moves toward the target by min(STEP, |target − cpu_freq|). On a clock with step_tick low, cpu_freq holds.
- R6: A target change in the middle of a ramp takes effect at once. The ramp continues from the present cpu_freq, in the direction of the new target.
- R7: pci_freq = round-to-nearest(preset_pci · cpu_freq / preset_cpu). It is registered on the same edge as cpu_freq, using the preset selected at that edge.
- R8: spread_mode is registered one clock after its inputs. Encoding: 0 = off, 1 = center, 2 = down. When spread_en is 0, spread_mode is 0. When spread_en is 1, indexes 23, 24 and 31 give 2 and every other index gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fs | input | 4 | Latched strap value for the low index nibble |
| reg_fs | input | 4 | Register value for the low index nibble |
| idx_hi | input | 1 | Top index bit |
| use_reg_sel | input | 1 | 1 selects reg_fs, 0 selects strap_fs |
| spread_en | input | 1 | Enables spread-mode reporting |
| fine_offset | input | MAG_W+1 (8) | Sign-magnitude fine step count |
| step_tick | input | 1 | Ramp strobe, one step per high clock |
| cpu_freq | output | FW (16) | Present CPU frequency, 10 kHz units |
| pci_freq | output | FW (16) | Present PCI frequency, 10 kHz units |
| spread_mode | output | 2 | 0 off, 1 center, 2 down |

## Verification
The bench builds the block with its defaults: FW = 16, STEP = 22, MAG_W = 7, slewing on and round-to-nearest scaling. With these values both ends of the offset range are reachable, +127 and −127 steps on the lowest preset, and the sums stay positive and within range. Round-to-nearest also brings PCI results whose remainder lands just above or just below one half. The step size makes ramps possible that end on an exact multiple of the step and ramps that end on a shorter final step. It also allows a target to be reversed in the middle of a ramp.

// File: rtl/freq_microstep_pkg.sv
package freq_microstep_pkg;

   typedef enum logic [1:0] {
      SPR_OFF    = 2'd0,
      SPR_CENTER = 2'd1,
      SPR_DOWN   = 2'd2
   } spread_e;

   localparam int IDX_W       = 5;
   localparam int LO_W        = 4;
   localparam int TBL_W       = 16;
   localparam int TBL_MIN_CPU = 6680;
   localparam int TBL_MAX_CPU = 15500;

   // Preset CPU frequency, 10 kHz units
   function automatic logic [TBL_W-1:0] cpu_base_of(input logic [IDX_W-1:0] i);
      logic [TBL_W-1:0] v;
      case (i)
         5'd0:  v = 16'd12400;  5'd1:  v = 16'd7500;   5'd2:  v = 16'd8330;   5'd3:  v = 16'd6680;
         5'd4:  v = 16'd10300;  5'd5:  v = 16'd11200;  5'd6:  v = 16'd13330;  5'd7:  v = 16'd10000;
         5'd8:  v = 16'd12000;  5'd9:  v = 16'd11500;  5'd10: v = 16'd11000;  5'd11: v = 16'd10500;
         5'd12: v = 16'd14000;  5'd13: v = 16'd15000;  5'd14: v = 16'd12400;  5'd15: v = 16'd13330;
         5'd16: v = 16'd9000;   5'd17: v = 16'd9250;   5'd18: v = 16'd9500;   5'd19: v = 16'd9750;
         5'd20: v = 16'd10150;  5'd21: v = 16'd12700;  5'd22: v = 16'd13650;  5'd23: v = 16'd10000;
         5'd24: v = 16'd12000;  5'd25: v = 16'd11750;  5'd26: v = 16'd12200;  5'd27: v = 16'd10750;
         5'd28: v = 16'd14500;  5'd29: v = 16'd15500;  5'd30: v = 16'd13000;  default: v = 16'd13330;
      endcase
      return v;
   endfunction

   // Preset PCI frequency, 10 kHz units
   function automatic logic [TBL_W-1:0] pci_base_of(input logic [IDX_W-1:0] i);
      logic [TBL_W-1:0] v;
      case (i)
         5'd0:  v = 16'd4130;  5'd1:  v = 16'd3750;  5'd2:  v = 16'd4170;  5'd3:  v = 16'd3340;
         5'd4:  v = 16'd3430;  5'd5:  v = 16'd3730;  5'd6:  v = 16'd4440;  5'd7:  v = 16'd3330;
         5'd8:  v = 16'd4000;  5'd9:  v = 16'd3830;  5'd10: v = 16'd3670;  5'd11: v = 16'd3500;
         5'd12: v = 16'd3500;  5'd13: v = 16'd3750;  5'd14: v = 16'd3100;  5'd15: v = 16'd3330;
         5'd16: v = 16'd3000;  5'd17: v = 16'd3080;  5'd18: v = 16'd3170;  5'd19: v = 16'd3250;
         5'd20: v = 16'd3380;  5'd21: v = 16'd4230;  5'd22: v = 16'd3410;  5'd23: v = 16'd3330;
         5'd24: v = 16'd4000;  5'd25: v = 16'd3920;  5'd26: v = 16'd4070;  5'd27: v = 16'd3580;
         5'd28: v = 16'd3630;  5'd29: v = 16'd3870;  5'd30: v = 16'd3250;  default: v = 16'd3330;
      endcase
      return v;
   endfunction

   function automatic logic is_down_spread(input logic [IDX_W-1:0] i);
      return (i == 5'd23) || (i == 5'd24) || (i == 5'd31);
   endfunction

endpackage

// File: rtl/freq_microstep_idx.sv
module freq_microstep_idx
   import freq_microstep_pkg::*;
(
   input  logic             use_reg,
   input  logic             hi_bit,
   input  logic [LO_W-1:0]  reg_lo,
   input  logic [LO_W-1:0]  strap_lo,
   output logic [IDX_W-1:0] idx
);
   // Low nibble source chosen by the control bit; top bit always from register
   always_comb begin
      idx = {hi_bit, (use_reg ? reg_lo : strap_lo)};
   end
endmodule

// File: rtl/freq_microstep_tgt.sv
module freq_microstep_tgt
   import freq_microstep_pkg::*;
#(
   parameter int FW    = 16,
   parameter int STEP  = 22,
   parameter int MAG_W = 7
)(
   input  logic [IDX_W-1:0] idx,
   input  logic [MAG_W:0]   offset,
   output logic [FW-1:0]    base_cpu,
   output logic [FW-1:0]    base_pci,
   output logic [FW-1:0]    tgt
);
   localparam logic [FW-1:0] STEP_V = FW'(STEP);

   logic [FW-1:0] mag_ext;
   logic [FW-1:0] delta;

   always_comb begin
      base_cpu = FW'(cpu_base_of(idx));
      base_pci = FW'(pci_base_of(idx));
      mag_ext  = {{(FW-MAG_W){1'b0}}, offset[MAG_W-1:0]};
      delta    = STEP_V * mag_ext;
      tgt      = offset[MAG_W] ? (base_cpu - delta) : (base_cpu + delta);
   end
endmodule

// File: rtl/freq_microstep_slew.sv
module freq_microstep_slew #(
   parameter int FW      = 16,
   parameter int STEP    = 22,
   parameter bit SLEW_EN = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [FW-1:0] tgt,
   output logic [FW-1:0] cur,
   output logic [FW-1:0] cur_nxt,
   output logic          primed
);
   localparam logic [FW-1:0] STEP_V = FW'(STEP);

   logic [FW-1:0] cur_q;
   logic          primed_q;

   generate
      if (SLEW_EN) begin : g_ramp
         always_comb begin
            cur_nxt = cur_q;
            if (!primed_q) begin
               cur_nxt = tgt;
            end else if (tick) begin
               if (tgt > cur_q) begin
                  cur_nxt = ((tgt - cur_q) > STEP_V) ? (cur_q + STEP_V) : tgt;
               end else if (tgt < cur_q) begin
                  cur_nxt = ((cur_q - tgt) > STEP_V) ? (cur_q - STEP_V) : tgt;
               end
            end
         end
      end else begin : g_jump
         always_comb begin
            cur_nxt = tgt;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q    <= '0;
         primed_q <= 1'b0;
      end else begin
         cur_q    <= cur_nxt;
         primed_q <= 1'b1;
      end
   end

   assign cur    = cur_q;
   assign primed = primed_q;
endmodule

// File: rtl/freq_microstep_scale.sv
module freq_microstep_scale #(
   parameter int FW            = 16,
   parameter bit ROUND_NEAREST = 1'b1
)(
   input  logic [FW-1:0] base_cpu,
   input  logic [FW-1:0] base_pci,
   input  logic [FW-1:0] cpu_now,
   output logic [FW-1:0] pci_now
);
   localparam int PW = 2 * FW;

   logic [PW-1:0] num;
   logic [PW-1:0] den;
   logic [PW-1:0] bias;
   logic [PW-1:0] quo;

   generate
      if (ROUND_NEAREST) begin : g_near
         assign bias = den >> 1;
      end else begin : g_trunc
         assign bias = '0;
      end
   endgenerate

   always_comb begin
      num     = PW'(base_pci) * PW'(cpu_now);
      den     = PW'(base_cpu);
      quo     = (den == '0) ? '0 : ((num + bias) / den);
      pci_now = quo[FW-1:0];
   end
endmodule

// File: rtl/freq_microstep.sv
module freq_microstep
   import freq_microstep_pkg::*;
#(
   parameter int FW            = 16,
   parameter int STEP          = 22,
   parameter int MAG_W         = 7,
   parameter bit SLEW_EN       = 1'b1,
   parameter bit ROUND_NEAREST = 1'b1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [3:0]      strap_fs,
   input  logic [3:0]      reg_fs,
   input  logic            idx_hi,
   input  logic            use_reg_sel,
   input  logic            spread_en,
   input  logic [MAG_W:0]  fine_offset,
   input  logic            step_tick,
   output logic [FW-1:0]   cpu_freq,
   output logic [FW-1:0]   pci_freq,
   output logic [1:0]      spread_mode
);
   localparam int MAX_OFF = STEP * ((1 << MAG_W) - 1);

   // Elaboration-time parameter checks
   if (FW < TBL_W) begin : g_fw_chk
      $error("freq_microstep: FW too narrow for preset table");
   end
   if (STEP < 1) begin : g_step_chk
      $error("freq_microstep: STEP must be positive");
   end
   if (MAX_OFF >= TBL_MIN_CPU) begin : g_under_chk
      $error("freq_microstep: negative offset can underflow");
   end
   if (FW < 31) begin : g_over_chk
      if (TBL_MAX_CPU + MAX_OFF >= (1 << FW)) begin : g_over
         $error("freq_microstep: positive offset can overflow FW");
      end
   end

   logic [IDX_W-1:0] idx_w;
   logic [FW-1:0]    base_cpu_w;
   logic [FW-1:0]    base_pci_w;
   logic [FW-1:0]    tgt_w;
   logic [FW-1:0]    cur_w;
   logic [FW-1:0]    cur_nxt_w;
   logic             primed_w;
   logic [FW-1:0]    pci_nxt_w;
   logic [FW-1:0]    pci_q;
   spread_e          spread_c;
   spread_e          spread_q;

   freq_microstep_idx u_idx (
      .use_reg  (use_reg_sel),
      .hi_bit   (idx_hi),
      .reg_lo   (reg_fs),
      .strap_lo (strap_fs),
      .idx      (idx_w)
   );

   freq_microstep_tgt #(.FW(FW), .STEP(STEP), .MAG_W(MAG_W)) u_tgt (
      .idx      (idx_w),
      .offset   (fine_offset),
      .base_cpu (base_cpu_w),
      .base_pci (base_pci_w),
      .tgt      (tgt_w)
   );

   freq_microstep_slew #(.FW(FW), .STEP(STEP), .SLEW_EN(SLEW_EN)) u_slew (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (step_tick),
      .tgt     (tgt_w),
      .cur     (cur_w),
      .cur_nxt (cur_nxt_w),
      .primed  (primed_w)
   );

   freq_microstep_scale #(.FW(FW), .ROUND_NEAREST(ROUND_NEAREST)) u_scale (
      .base_cpu (base_cpu_w),
      .base_pci (base_pci_w),
      .cpu_now  (cur_nxt_w),
      .pci_now  (pci_nxt_w)
   );

   always_comb begin
      if (!spread_en)                 spread_c = SPR_OFF;
      else if (is_down_spread(idx_w)) spread_c = SPR_DOWN;
      else                            spread_c = SPR_CENTER;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pci_q    <= '0;
         spread_q <= SPR_OFF;
      end else begin
         pci_q    <= pci_nxt_w;
         spread_q <= spread_c;
      end
   end

   assign cpu_freq    = cur_w;
   assign pci_freq    = pci_q;
   assign spread_mode = spread_q;
endmodule

// File: rtl/freq_microstep_chk.sv
module freq_microstep_chk #(
   parameter int FW      = 16,
   parameter int STEP    = 22,
   parameter bit SLEW_EN = 1'b1
)(
   input logic          clk,
   input logic          rst_n,
   input logic          step_tick,
   input logic          spread_en,
   input logic [FW-1:0] cpu_freq,
   input logic [FW-1:0] pci_freq,
   input logic [1:0]    spread_mode,
   input logic          primed,
   input logic [FW-1:0] target
);
   localparam logic [FW-1:0] STEP_V = FW'(STEP);

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_zero_chk: assert (cpu_freq == '0 && pci_freq == '0 && spread_mode == 2'd0)
            else $error("outputs not cleared in reset");
      end
   end

   generate
      if (SLEW_EN) begin : g_slew_props
         // R5
         hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && !step_tick) |=> $stable(cpu_freq));

         // R5
         step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed |=> ((cpu_freq >= $past(cpu_freq)) ?
                        ((cpu_freq - $past(cpu_freq)) <= STEP_V) :
                        (($past(cpu_freq) - cpu_freq) <= STEP_V)));

         // R6
         toward_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && step_tick && cpu_freq < target) |=>
            (cpu_freq > $past(cpu_freq) && cpu_freq <= $past(target)));

         // R6
         toward_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && step_tick && cpu_freq > target) |=>
            (cpu_freq < $past(cpu_freq) && cpu_freq >= $past(target)));
      end
   endgenerate

   // R8
   spread_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !spread_en |=> (spread_mode == 2'd0));

   // R8
   spread_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spread_mode != 2'd3);

   // R7
   pci_below_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pci_freq <= cpu_freq);
endmodule

bind freq_microstep freq_microstep_chk #(.FW(FW), .STEP(STEP), .SLEW_EN(SLEW_EN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .step_tick   (step_tick),
   .spread_en   (spread_en),
   .cpu_freq    (cpu_freq),
   .pci_freq    (pci_freq),
   .spread_mode (spread_mode),
   .primed      (primed_w),
   .target      (tgt_w)
);

// File: tb/freq_microstep_test.sv
module freq_microstep_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 50000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  strap_fs = 4'b0111;
   logic [3:0]  reg_fs = 4'b0000;
   logic        idx_hi = 1'b0;
   logic        use_reg_sel = 1'b0;
   logic        spread_en = 1'b1;
   logic [7:0]  fine_offset = 8'h00;
   logic        step_tick = 1'b0;
   logic [15:0] cpu_freq;
   logic [15:0] pci_freq;
   logic [1:0]  spread_mode;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   freq_microstep uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .strap_fs    (strap_fs),
      .reg_fs      (reg_fs),
      .idx_hi      (idx_hi),
      .use_reg_sel (use_reg_sel),
      .spread_en   (spread_en),
      .fine_offset (fine_offset),
      .step_tick   (step_tick),
      .cpu_freq    (cpu_freq),
      .pci_freq    (pci_freq),
      .spread_mode (spread_mode)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int exp_pci(input int pb, input int cb, input int cur);
      return (2 * pb * cur + cb) / (2 * cb);
   endfunction

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      step_tick = 1'b1;
      for (int i = 0; i < n; i++) @(negedge clk);
      step_tick = 1'b0;
   endtask

   // R1 R2 R7 R8: reset state and load from straps
   task automatic t_reset;
      rst_n = 1'b0;
      idle(3);
      check("R1", "cpu in reset", int'(cpu_freq), 0);
      check("R1", "pci in reset", int'(pci_freq), 0);
      check("R1", "spread in reset", int'(spread_mode), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "cpu loaded at once", int'(cpu_freq), 10000);
      check("R7", "pci after load", int'(pci_freq), 3330);
      check("R8", "center spread idx7", int'(spread_mode), 1);
   endtask

   // R2 R5 R7: switch to register nibble, hold without tick, ramp, ignore strap
   task automatic t_reg_select;
      use_reg_sel = 1'b1;
      idle(3);
      check("R5", "hold without tick", int'(cpu_freq), 10000);
      check("R7", "pci rescaled to new preset", int'(pci_freq), exp_pci(4130, 12400, 10000));
      ticks(109);
      check("R5", "ramp 109 steps", int'(cpu_freq), 12398);
      ticks(1);
      check("R5", "short last step", int'(cpu_freq), 12400);
      check("R7", "pci at preset", int'(pci_freq), 4130);
      strap_fs = 4'b0011;
      ticks(3);
      check("R2", "strap ignored when reg selected", int'(cpu_freq), 12400);
      check("R2", "strap ignored pci", int'(pci_freq), 4130);
   endtask

   // R3 R4 R7: preset 22 with positive, negative and negative-zero offsets
   task automatic t_offset;
      idx_hi = 1'b1;
      reg_fs = 4'b0110;
      ticks(57);
      check("R3", "preset 22 cpu", int'(cpu_freq), 13650);
      check("R3", "preset 22 pci", int'(pci_freq), 3410);
      fine_offset = 8'h0B;
      ticks(11);
      check("R4", "plus 11 steps", int'(cpu_freq), 13892);
      check("R7", "pci at plus 11", int'(pci_freq), 3470);
      fine_offset = 8'h8B;
      ticks(22);
      check("R4", "minus 11 steps", int'(cpu_freq), 13408);
      check("R7", "pci rounds up", int'(pci_freq), exp_pci(3410, 13650, 13408));
      fine_offset = 8'h80;
      ticks(11);
      check("R4", "negative zero", int'(cpu_freq), 13650);
   endtask

   // R6: reversal of direction mid-ramp
   task automatic t_retarget;
      fine_offset = 8'h0A;
      ticks(4);
      check("R6", "partway up", int'(cpu_freq), 13738);
      fine_offset = 8'h81;
      ticks(1);
      check("R6", "turns down from current", int'(cpu_freq), 13716);
      ticks(4);
      check("R6", "reaches new target", int'(cpu_freq), 13628);
      check("R7", "pci half rounding", int'(pci_freq), exp_pci(3410, 13650, 13628));
   endtask

   // R3 R4: extremes of offset on lowest preset
   task automatic t_extremes;
      idx_hi = 1'b0;
      reg_fs = 4'b0011;
      fine_offset = 8'hFF;
      ticks(443);
      check("R4", "minus 127 steps", int'(cpu_freq), 3886);
      check("R3", "pci preset 3 scaled", int'(pci_freq), 1943);
      fine_offset = 8'h7F;
      ticks(254);
      check("R4", "plus 127 steps", int'(cpu_freq), 9474);
      check("R7", "pci at plus 127", int'(pci_freq), 4737);
   endtask

   // R8: spread mode selection
   task automatic t_spread;
      spread_en = 1'b0;
      @(negedge clk);
      check("R8", "spread disabled", int'(spread_mode), 0);
      spread_en = 1'b1;
      @(negedge clk);
      check("R8", "center on idx3", int'(spread_mode), 1);
      idx_hi = 1'b1; reg_fs = 4'b0111;
      @(negedge clk);
      check("R8", "down on idx23", int'(spread_mode), 2);
      reg_fs = 4'b1000;
      @(negedge clk);
      check("R8", "down on idx24", int'(spread_mode), 2);
      reg_fs = 4'b1111;
      @(negedge clk);
      check("R8", "down on idx31", int'(spread_mode), 2);
      reg_fs = 4'b0110;
      @(negedge clk);
      check("R8", "center on idx22", int'(spread_mode), 1);
      spread_en = 1'b0;
      @(negedge clk);
      check("R8", "disabled on idx22", int'(spread_mode), 0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_reg_select();
      t_offset();
      t_retarget();
      t_extremes();
      t_spread();
      finish_run();
   end
endmodule